// File: doc/BRIEF.md
# SMI Nesting and Interrupt Gating Controller

This block tracks whether the processor is in system-management mode (SMM) and decides, cycle by cycle, which interrupt requests the core may take. A system-management interrupt (SMI) is always taken outside SMM. Inside SMM it is taken only when software has enabled nesting. Maskable interrupts (INTR) pass only while an internal interrupt flag is set. Taking an SMI clears that flag and software sets it again with a strobe. Non-maskable interrupts (NMI) inside SMM are held back unless the NMI-enable control bit is high.

A masked NMI is held in a one-deep latch. It is delivered once NMI becomes enabled or once the block has left SMM. Each taken SMI produces a nested-status bit that the surrounding logic stores in the saved state header. On a resume strobe, the same bit read back from the header decides whether the block stays in SMM or leaves it.

All request and control inputs are sampled on the rising clock edge. Every accept output is a registered pulse in the cycle after the request edge.

Top module: `smi_gate_ctrl`

## Requirements
- R1: After reset, or while rst_ni is low, in_smm_o, nested_o and all accept outputs are 0, the interrupt flag is clear and no NMI is pending.
- R2: Outside SMM, an SMI request is always taken: smi_ack_o is 1 for the next cycle, and in_smm_o is 1 from that cycle on.
- R3: On every taken SMI, nested_o takes the value in_smm_o had at the request edge (1 = nested, 0 = first level) and holds it until the next taken SMI.
- R4: Inside SMM, an SMI request with nest_en_i low is dropped: there is no ack, and in_smm_o and nested_o do not change.
- R5: A resume strobe in SMM keeps in_smm_o at 1 when hdr_nested_i is 1 and clears it when hdr_nested_i is 0. A resume outside SMM is ignored. A resume in the same cycle as a taken SMI is ignored.
- R6: An INTR request gives intr_ack_o only while the interrupt flag is set. if_set_i sets the flag, which takes effect from the following edge. A taken SMI clears the flag, and the clear wins over a set in the same cycle.
- R7: Outside SMM an NMI request is acknowledged in the next cycle. Inside SMM it is acknowledged only while nmi_en_i is 1.
- R8: An NMI that is blocked is latched once. It is acknowledged exactly once, at the first edge where it is allowed: after nmi_en_i rises, or the edge after SMM is left. Further NMIs that arrive while one is latched are discarded.
- R9: When an SMI is taken, any NMI or INTR request in the same cycle is not acknowledged. The NMI is latched under R8, and the INTR is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smi_req_i | input | 1 | SMI request strobe |
| intr_req_i | input | 1 | Maskable interrupt request strobe |
| nmi_req_i | input | 1 | Non-maskable interrupt request strobe |
| rsm_i | input | 1 | Resume-from-SMM strobe |
| nest_en_i | input | 1 | Allow SMI while in SMM |
| nmi_en_i | input | 1 | Allow NMI while in SMM |
| if_set_i | input | 1 | Set the interrupt flag |
| hdr_nested_i | input | 1 | Nested-status bit restored from the header on resume |
| smi_ack_o | output | 1 | SMI accepted pulse |
| intr_ack_o | output | 1 | INTR accepted pulse |
| nmi_ack_o | output | 1 | NMI accepted pulse |
| in_smm_o | output | 1 | Block is in SMM |
| nested_o | output | 1 | Nested-status bit to store on SMI entry |

## Verification
All three accept pulses, in_smm_o and nested_o change one edge after the request that causes them. The bench drives each vector at the falling edge and samples a quarter period after the next rising edge. A latched NMI is delivered one edge after the enabling condition appears. When that condition is leaving SMM, this is two edges after the resume strobe, and the table spends an idle vector on it. The interrupt flag set is checked the same way: an INTR in the set cycle is refused, and one in the following cycle is taken.

// File: rtl/smi_gate_pkg.sv
package smi_gate_pkg;
  typedef struct packed {
    logic smi;
    logic intr;
    logic nmi;
  } irq_vec_t;
endpackage

// File: rtl/smm_state_trk.sv
module smm_state_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smi_req_i,
  input  logic nest_en_i,
  input  logic rsm_i,
  input  logic hdr_nested_i,
  output logic smi_take_o,
  output logic smi_ack_o,
  output logic in_smm_o,
  output logic nested_o
);
  logic in_smm_q, nested_q, ack_q;

  assign smi_take_o = smi_req_i & (~in_smm_q | nest_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_smm_q <= 1'b0;
      nested_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= smi_take_o;
      if (smi_take_o) begin
        nested_q <= in_smm_q;
        in_smm_q <= 1'b1;
      end else if (rsm_i && in_smm_q) begin
        in_smm_q <= hdr_nested_i;
      end
    end
  end

  assign smi_ack_o = ack_q;
  assign in_smm_o  = in_smm_q;
  assign nested_o  = nested_q;

  a_r2_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_req_i && !in_smm_o) |=> (smi_ack_o && in_smm_o));
  a_r3_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_ack_o |-> (nested_o == $past(in_smm_o)));
  a_r4_no_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_smm_o && !nest_en_i) |=> (!smi_ack_o && $stable(nested_o)));
  a_r5_rsm_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_smm_o && !smi_req_i) |=> !in_smm_o);
endmodule

// File: rtl/nmi_gate.sv
module nmi_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_req_i,
  input  logic in_smm_i,
  input  logic nmi_en_i,
  input  logic block_i,
  output logic nmi_ack_o
);
  logic pend_q, ack_q, allowed, avail;

  assign allowed = (~in_smm_i | nmi_en_i) & ~block_i;
  assign avail   = nmi_req_i | pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= avail & allowed;
      if (allowed)        pend_q <= 1'b0;
      else if (nmi_req_i) pend_q <= 1'b1;  // second request while pending is dropped
    end
  end

  assign nmi_ack_o = ack_q;

  a_r7_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_smm_i && !nmi_en_i) |=> !nmi_ack_o);
  a_r8_latch_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_req_i && !allowed) |=> pend_q);
endmodule

// File: rtl/intr_gate.sv
module intr_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic intr_req_i,
  input  logic if_set_i,
  input  logic smi_take_i,
  output logic intr_ack_o
);
  logic flag_q, ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= intr_req_i & flag_q & ~smi_take_i;
      if (smi_take_i)    flag_q <= 1'b0;
      else if (if_set_i) flag_q <= 1'b1;
    end
  end

  assign intr_ack_o = ack_q;

  a_r6_flag_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q |=> !intr_ack_o);
endmodule

// File: rtl/smi_gate_ctrl.sv
module smi_gate_ctrl
  import smi_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smi_req_i,
  input  logic intr_req_i,
  input  logic nmi_req_i,
  input  logic rsm_i,
  input  logic nest_en_i,
  input  logic nmi_en_i,
  input  logic if_set_i,
  input  logic hdr_nested_i,
  output logic smi_ack_o,
  output logic intr_ack_o,
  output logic nmi_ack_o,
  output logic in_smm_o,
  output logic nested_o
);
  irq_vec_t ack;
  logic smi_take;

  smm_state_trk u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smi_req_i   (smi_req_i),
    .nest_en_i   (nest_en_i),
    .rsm_i       (rsm_i),
    .hdr_nested_i(hdr_nested_i),
    .smi_take_o  (smi_take),
    .smi_ack_o   (ack.smi),
    .in_smm_o    (in_smm_o),
    .nested_o    (nested_o)
  );

  nmi_gate u_nmi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .nmi_req_i(nmi_req_i),
    .in_smm_i (in_smm_o),
    .nmi_en_i (nmi_en_i),
    .block_i  (smi_take),
    .nmi_ack_o(ack.nmi)
  );

  intr_gate u_intr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .intr_req_i(intr_req_i),
    .if_set_i  (if_set_i),
    .smi_take_i(smi_take),
    .intr_ack_o(ack.intr)
  );

  assign smi_ack_o  = ack.smi;
  assign intr_ack_o = ack.intr;
  assign nmi_ack_o  = ack.nmi;

  a_r9_smi_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_ack_o |-> (!nmi_ack_o && !intr_ack_o));
  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!in_smm_o && !smi_ack_o && !nmi_ack_o && !intr_ack_o));
endmodule

// File: tb/smi_gate_ctrl_test.sv
module smi_gate_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic smi_req, intr_req, nmi_req, rsm, nest_en, nmi_en, if_set, hdr_nested;
  logic smi_ack, intr_ack, nmi_ack, in_smm, nested;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_gate_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .smi_req_i(smi_req), .intr_req_i(intr_req), .nmi_req_i(nmi_req),
    .rsm_i(rsm), .nest_en_i(nest_en), .nmi_en_i(nmi_en),
    .if_set_i(if_set), .hdr_nested_i(hdr_nested),
    .smi_ack_o(smi_ack), .intr_ack_o(intr_ack), .nmi_ack_o(nmi_ack),
    .in_smm_o(in_smm), .nested_o(nested)
  );

  // {req[3:0], smi,intr,nmi,rsm,nest_en,nmi_en,if_set,hdr, smi_ack,intr_ack,nmi_ack,in_smm,nested}
  localparam logic [16:0] VEC [NVEC] = '{
    {4'd7, 8'b0010_0000, 5'b00100}, // R7 NMI outside SMM
    {4'd6, 8'b0100_0000, 5'b00000}, // R6 flag clear
    {4'd6, 8'b0000_0010, 5'b00000}, // R6 set flag
    {4'd6, 8'b0100_0000, 5'b01000}, // R6 INTR taken
    {4'd9, 8'b1110_0000, 5'b10010}, // R9 SMI wins, NMI latched
    {4'd6, 8'b0100_0000, 5'b00010}, // R6 flag cleared by SMI
    {4'd8, 8'b0010_0000, 5'b00010}, // R8 second NMI dropped
    {4'd4, 8'b1000_0000, 5'b00010}, // R4 no nesting
    {4'd8, 8'b0000_0100, 5'b00110}, // R8 latched NMI served
    {4'd8, 8'b0000_0100, 5'b00010}, // R8 only once
    {4'd3, 8'b1000_1000, 5'b10011}, // R3 nested entry
    {4'd5, 8'b0001_0001, 5'b00011}, // R5 stay
    {4'd8, 8'b0010_0000, 5'b00011}, // R8 latch
    {4'd5, 8'b0001_0000, 5'b00001}, // R5 leave
    {4'd8, 8'b0000_0000, 5'b00101}, // R8 served after leaving
    {4'd5, 8'b0001_0001, 5'b00001}, // R5 resume outside ignored
    {4'd2, 8'b1000_0000, 5'b10010}, // R2 enter, nested 0
    {4'd5, 8'b1001_1000, 5'b10011}, // R5 SMI overrides resume
    {4'd5, 8'b0001_0000, 5'b00001}, // R5 leave
    {4'd6, 8'b1000_0010, 5'b10010}, // R6 clear wins over set
    {4'd6, 8'b0100_0000, 5'b00010}, // R6 flag still clear
    {4'd6, 8'b0100_0010, 5'b00010}, // R6 set not yet effective
    {4'd6, 8'b0100_0000, 5'b01010}, // R6 INTR in SMM
    {4'd5, 8'b0001_0000, 5'b00000}  // R5 leave
  };

  task automatic drive(input logic [7:0] s);
    {smi_req, intr_req, nmi_req, rsm, nest_en, nmi_en, if_set, hdr_nested} = s;
  endtask

  task automatic check(input int req, input logic [4:0] exp, input int idx);
    logic [4:0] act;
    act = {smi_ack, intr_ack, nmi_ack, in_smm, nested};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d step %0d actual=%b expected=%b", req, idx, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] s, input int req, input logic [4:0] exp, input int idx);
    @(negedge clk);
    drive(s);
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(req, exp, idx);
  endtask

  initial begin
    drive(8'h00);
    #(CLK_PERIOD*3);
    check(1, 5'b00000, -1); // R1 during reset
    @(negedge clk);
    rst_ni = 1'b1;
    step(8'h00, 1, 5'b00000, -2); // R1 after reset
    for (int i = 0; i < NVEC; i++)
      step(VEC[i][12:5], int'(VEC[i][16:13]), VEC[i][4:0], i);
    // R1: reset in SMM clears state
    step(8'b1000_0010, 2, 5'b10010, 100);
    step(8'b0010_0000, 8, 5'b00010, 101);
    @(negedge clk);
    drive(8'h00);
    rst_ni = 1'b0;
    #(CLK_PERIOD/4);
    check(1, 5'b00000, 102);
    @(negedge clk);
    rst_ni = 1'b1;
    step(8'b0000_0100, 1, 5'b00000, 103); // R1 no pending NMI survives
    step(8'b0100_0000, 1, 5'b00000, 104); // R1 flag clear after reset
    step(8'b0010_0000, 7, 5'b00100, 105); // R7
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule